// File: doc/BRIEF.md
# UART Receive Queue with Per-Entry Error Tracking

This block sits between a UART deserializer and the host-side register file. Each byte the deserializer delivers is stored together with its own error tags: parity, framing, break, and a fourth tag for overrun that the queue adds itself. The host pops bytes with a read strobe. While the queue holds at least one byte, the byte at the head and its tags are shown at the outputs.

Three indications are derived from the stored state:
- **Data-ready** follows a programmable fill threshold.
- **Character time-out** fires when a partial queue has sat untouched for four byte times. It then holds until the queue is drained.
- **Error indications** come in two forms. A head-error line reflects only the tags of the entry about to be read. An aggregate error bit stays set while any tagged entry remains stored.

A single enable selects between the 16-entry queue and a one-byte holding mode. Any change of that enable empties the queue.

Top module: `uart_rx_queue`

## Requirements
- R1: With `fifo_en_i`=1 the block stores up to 16 bytes and returns them first-in first-out. While `count_o` is nonzero, `rd_data_o` shows the oldest byte. `rd_i` removes it at the next clock edge. `rd_i` while empty has no effect.
- R2: With `fifo_en_i`=1, `data_ready_o` is high while `count_o` >= the selected level. The `trig_sel_i` encoding is 0→1, 1→4, 2→8, 3→14.
- R3: With `fifo_en_i`=0 the block holds at most one byte. `data_ready_o` is high while that byte is held and drops after it is read.
- R4: A byte arriving while the queue is full and no read happens in the same cycle is discarded. In that case the overrun tag (`rd_flags_o[3]`) is set on the most recently stored entry. A byte arriving on a full queue in the same cycle as a read is stored.
- R5: `rd_flags_o` gives the tags of the head entry: bit 0 parity, bit 1 framing, bit 2 break, bit 3 overrun. `line_err_o` is high while `count_o` is nonzero and the head entry has any tag set.
- R6: `err_any_o` is high while at least one stored entry carries any tag.
- R7: An idle counter clears on any cycle with `rx_valid_i` or an accepted read. Otherwise it counts `tick_i` pulses, saturating at 4. `timeout_o` rises one cycle after the counter reaches 4, provided `fifo_en_i`=1 and 0 < `count_o` < the selected level.
- R8: Once high, `timeout_o` stays high through further writes, reads and threshold crossings until `count_o` reaches zero.
- R9: A change of `fifo_en_i` empties the queue at the next edge. That cycle's write and read are dropped, and time-out and aggregate error are cleared.
- R10: After reset, `count_o`, `data_ready_o`, `timeout_o`, `line_err_o` and `err_any_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1: 16-entry queue, 0: single holding byte |
| trig_sel_i | input | 2 | Data-ready threshold select |
| tick_i | input | 1 | One pulse per received byte time |
| rx_valid_i | input | 1 | Byte strobe from the deserializer |
| rx_data_i | input | 8 | Received byte |
| rx_par_err_i | input | 1 | Parity error (address mark for 9-bit data) |
| rx_frm_err_i | input | 1 | Stop bit missing |
| rx_brk_i | input | 1 | Break detected |
| rd_i | input | 1 | Host read strobe |
| rd_data_o | output | 8 | Head byte |
| rd_flags_o | output | 4 | Head tags {overrun, break, framing, parity} |
| count_o | output | 5 | Number of stored bytes |
| data_ready_o | output | 1 | Data-ready indication |
| timeout_o | output | 1 | Character time-out |
| line_err_o | output | 1 | Head entry has an error |
| err_any_o | output | 1 | Some stored entry has an error |

## Verification
The hardest state to reach is a full queue hit by a further byte. Whether that byte is stored or discarded depends on whether a read lands in the same cycle. When it is discarded, the overrun tag must land on the newest entry, which only becomes visible fifteen reads later.

The stimulus fills the queue completely and then offers one byte with no read and one byte with a read. It drains down to the tagged entry and inspects it at the head.

Time-out is driven separately: a partial queue receives exactly four ticks, followed by writes that push it past the threshold. This shows the indication holding until the last byte leaves.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  typedef struct packed {
    logic ovr;
    logic brk;
    logic frm;
    logic par;
  } rxq_flags_t;

  typedef enum logic [1:0] {
    TRIG_A = 2'd0,
    TRIG_B = 2'd1,
    TRIG_C = 2'd2,
    TRIG_D = 2'd3
  } trig_sel_e;

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          fifo_en_i,
  input  logic          push_i,
  input  logic          pop_req_i,
  input  logic [DW-1:0] din_i,
  input  rxq_flags_t    flags_i,
  output logic [DW-1:0] head_data_o,
  output rxq_flags_t    head_flags_o,
  output logic [CW-1:0] count_o,
  output logic          pop_o,
  output logic          push_err_o,
  output logic          pop_err_o,
  output logic          ovr_new_err_o
);

  localparam logic [CW-1:0] FULL_Q = CW'(DEPTH);
  localparam logic [CW-1:0] FULL_H = CW'(1);
  localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);

  logic [DW-1:0] data_mem [DEPTH];
  rxq_flags_t    flag_mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, last_idx;
  logic [CW-1:0] count_q, cap;
  logic          full, accept, ovr_hit;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign cap      = fifo_en_i ? FULL_Q : FULL_H;
  assign full     = (count_q >= cap);
  assign pop_o    = pop_req_i && (count_q != '0) && !flush_i;
  assign accept   = push_i && !flush_i && (!full || pop_o);
  assign ovr_hit  = push_i && !flush_i && full && !pop_o;
  assign last_idx = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;

  always_ff @(posedge clk_i) begin
    if (accept) data_mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) flag_mem[i] <= '0;
    end else if (accept) begin
      flag_mem[wr_ptr] <= flags_i;
    end else if (ovr_hit) begin
      flag_mem[last_idx].ovr <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (accept) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_o)  rd_ptr <= ptr_inc(rd_ptr);
      count_q <= count_q + CW'(accept) - CW'(pop_o);
    end
  end

  assign head_data_o   = data_mem[rd_ptr];
  assign head_flags_o  = flag_mem[rd_ptr];
  assign count_o       = count_q;
  assign push_err_o    = accept && (|flags_i);
  assign pop_err_o     = pop_o && (|head_flags_o);
  assign ovr_new_err_o = ovr_hit && !(|flag_mem[last_idx]);

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL_Q); // R1
  AST_EMPTY_READ_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_req_i && !push_i && !flush_i && count_q == '0) |=> count_q == '0); // R1
  AST_OVERRUN_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_req_i && !flush_i && count_q == cap) |=> $stable(count_q)); // R4
  AST_OVERRUN_TAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_req_i && !flush_i && count_q == cap) |=> flag_mem[$past(last_idx)].ovr); // R4

endmodule

// File: rtl/rxq_err_track.sv
module rxq_err_track #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_err_i,
  input  logic          pop_err_i,
  input  logic          ovr_new_err_i,
  input  logic [CW-1:0] count_i,
  output logic          err_any_o
);

  logic [CW-1:0] err_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_cnt <= '0;
    else if (flush_i) err_cnt <= '0;
    else              err_cnt <= err_cnt + CW'(push_err_i) + CW'(ovr_new_err_i) - CW'(pop_err_i);
  end

  assign err_any_o = (err_cnt != '0);

  AST_ERR_WITHIN_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt <= count_i); // R6
  AST_ERR_CLEARS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == '0) |-> !err_any_o); // R6

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int IDLE_LIMIT = 4,
  parameter int CW         = 5,
  parameter int IW         = $clog2(IDLE_LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          activity_i,
  input  logic          tick_i,
  input  logic          armed_i,
  input  logic [CW-1:0] count_i,
  output logic          timeout_o
);

  localparam logic [IW-1:0] LIM = IW'(IDLE_LIMIT);

  logic [IW-1:0] idle_q;
  logic          tmo_q, fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      idle_q <= '0;
    else if (flush_i || activity_i)   idle_q <= '0;
    else if (tick_i && idle_q != LIM) idle_q <= idle_q + 1'b1;
  end

  assign fire = (idle_q == LIM) && armed_i;

  // cleared one cycle late; output gating keeps it invisible
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               tmo_q <= 1'b0;
    else if (flush_i)          tmo_q <= 1'b0;
    else if (count_i == '0)    tmo_q <= 1'b0;
    else if (fire)             tmo_q <= 1'b1;
  end

  assign timeout_o = tmo_q && (count_i != '0);

  AST_TMO_AFTER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(idle_q == LIM)); // R7
  AST_TMO_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(timeout_o) |-> count_i == '0); // R8
  AST_IDLE_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q <= LIM); // R7

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int DW         = 8,
  parameter int IDLE_LIMIT = 4,
  parameter int LVL_A      = 1,
  parameter int LVL_B      = 4,
  parameter int LVL_C      = 8,
  parameter int LVL_D      = 14
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         fifo_en_i,
  input  logic [1:0]                   trig_sel_i,
  input  logic                         tick_i,
  input  logic                         rx_valid_i,
  input  logic [DW-1:0]                rx_data_i,
  input  logic                         rx_par_err_i,
  input  logic                         rx_frm_err_i,
  input  logic                         rx_brk_i,
  input  logic                         rd_i,
  output logic [DW-1:0]                rd_data_o,
  output logic [3:0]                   rd_flags_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         data_ready_o,
  output logic                         timeout_o,
  output logic                         line_err_o,
  output logic                         err_any_o
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          en_q, flush, pop, push_err, pop_err, ovr_new_err, armed;
  logic [CW-1:0] count, trig_lvl;
  rxq_flags_t    in_flags, head_flags;
  trig_sel_e     tsel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= fifo_en_i;
  end

  assign flush = (fifo_en_i != en_q);
  assign tsel  = trig_sel_e'(trig_sel_i);

  always_comb begin
    unique case (tsel)
      TRIG_A:  trig_lvl = CW'(LVL_A);
      TRIG_B:  trig_lvl = CW'(LVL_B);
      TRIG_C:  trig_lvl = CW'(LVL_C);
      default: trig_lvl = CW'(LVL_D);
    endcase
  end

  assign in_flags = '{ovr: 1'b0, brk: rx_brk_i, frm: rx_frm_err_i, par: rx_par_err_i};

  rxq_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .CW(CW)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush),
    .fifo_en_i    (fifo_en_i),
    .push_i       (rx_valid_i),
    .pop_req_i    (rd_i),
    .din_i        (rx_data_i),
    .flags_i      (in_flags),
    .head_data_o  (rd_data_o),
    .head_flags_o (head_flags),
    .count_o      (count),
    .pop_o        (pop),
    .push_err_o   (push_err),
    .pop_err_o    (pop_err),
    .ovr_new_err_o(ovr_new_err)
  );

  rxq_err_track #(.CW(CW)) u_err (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush),
    .push_err_i   (push_err),
    .pop_err_i    (pop_err),
    .ovr_new_err_i(ovr_new_err),
    .count_i      (count),
    .err_any_o    (err_any_o)
  );

  assign armed = fifo_en_i && (count != '0) && (count < trig_lvl);

  rxq_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT), .CW(CW)) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush),
    .activity_i(rx_valid_i || pop),
    .tick_i    (tick_i),
    .armed_i   (armed),
    .count_i   (count),
    .timeout_o (timeout_o)
  );

  assign count_o      = count;
  assign rd_flags_o   = head_flags;
  assign line_err_o   = (count != '0) && (|head_flags);
  assign data_ready_o = fifo_en_i ? (count >= trig_lvl) : (count != '0);

  AST_HEAD_ERR_COUNTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_err_o |-> err_any_o); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (count_o == '0 && !timeout_o)); // R9
  AST_HOLD_MODE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && !flush) |-> count_o <= CW'(1)); // R3

endmodule

// File: tb/uart_rx_queue_tb.sv
module uart_rx_queue_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0;
  logic [1:0] trig = 2'd0;
  logic       tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] din = '0;
  logic       par = 1'b0, frm = 1'b0, brk = 1'b0;
  logic [7:0] rd_data;
  logic [3:0] rd_flags;
  logic [4:0] count;
  logic       data_ready, timeout, line_err, err_any;

  always #4 clk = ~clk;

  uart_rx_queue u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .trig_sel_i(trig),
    .tick_i(tick), .rx_valid_i(wr), .rx_data_i(din), .rx_par_err_i(par),
    .rx_frm_err_i(frm), .rx_brk_i(brk), .rd_i(rd), .rd_data_o(rd_data),
    .rd_flags_o(rd_flags), .count_o(count), .data_ready_o(data_ready),
    .timeout_o(timeout), .line_err_o(line_err), .err_any_o(err_any)
  );

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // reference model: entry = {ovr,brk,frm,par,data}
  logic [11:0] q[$];
  int idle = 0;
  bit tmo = 0, prev_en = 0;

  function automatic int lvl(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); idle = 0; tmo = 0; prev_en = 0;
    end else if (fifo_en != prev_en) begin
      q.delete(); idle = 0; tmo = 0; prev_en = fifo_en;
    end else begin
      automatic int  cnt  = q.size();
      automatic int  cap  = fifo_en ? 16 : 1;
      automatic bit  pop  = rd && cnt != 0;
      automatic bit  fire = (idle == 4) && fifo_en && cnt != 0 && cnt < lvl(trig);
      if (pop) void'(q.pop_front());
      if (wr) begin
        if (cnt < cap || pop) q.push_back({1'b0, brk, frm, par, din});
        else q[q.size()-1][11] = 1'b1;
      end
      if (wr || pop) idle = 0;
      else if (tick && idle < 4) idle++;
      tmo = (q.size() == 0) ? 1'b0 : (tmo || fire);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit any_err();
    foreach (q[i]) if (q[i][11:8] != 0) return 1;
    return 0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      chk("R1 count", count, q.size());
      if (q.size() != 0) begin
        chk("R1 head data", rd_data, q[0][7:0]);
        chk("R5 head flags", rd_flags, q[0][11:8]);
      end
      if (fifo_en) chk("R2 data_ready", data_ready, q.size() >= lvl(trig));
      else         chk("R3 data_ready", data_ready, q.size() != 0);
      chk("R5 line_err", line_err, q.size() != 0 && q[0][11:8] != 0);
      chk("R6 err_any", err_any, any_err());
      chk("R7 R8 timeout", timeout, tmo);
    end
  end

  task automatic drive(input logic w, input logic [7:0] d, input logic [2:0] f,
                       input logic r, input logic t);
    wr = w; din = d; {brk, frm, par} = f; rd = r; tick = t;
    @(posedge clk); #2;
  endtask

  task automatic idle_cyc(); drive(0, 8'h00, 3'b000, 0, 0); endtask
  task automatic put(input logic [7:0] d, input logic [2:0] f); drive(1, d, f, 0, 0); endtask
  task automatic take(); drive(0, 8'h00, 3'b000, 1, 0); endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    vectors++; chk("R10 count", count, 0);
    vectors++; chk("R10 flags", {data_ready, timeout, line_err, err_any}, 0);
    @(posedge clk); #2;

    // R2 thresholds
    fifo_en = 1; trig = 2'd2; idle_cyc();
    for (int i = 0; i < 7; i++) put(8'h30 + 8'(i), 3'b000);
    #1 vectors++; chk("R2 below level", data_ready, 0);
    put(8'h37, 3'b000);
    #1 vectors++; chk("R2 at level", data_ready, 1);
    for (int i = 0; i < 8; i++) take();
    take();  // R1 read while empty
    #1 vectors++; chk("R1 empty read", count, 0);

    // R7 R8 time-out
    trig = 2'd1;
    put(8'hA1, 3'b000); put(8'hA2, 3'b000);
    for (int i = 0; i < 4; i++) drive(0, 8'h00, 3'b000, 0, 1);
    #1 vectors++; chk("R7 not yet", timeout, 0);
    idle_cyc();
    #1 vectors++; chk("R7 raised", timeout, 1);
    for (int i = 0; i < 3; i++) put(8'hB0 + 8'(i), 3'b000);
    #1 vectors++; chk("R8 above level", timeout, 1);
    for (int i = 0; i < 4; i++) take();
    #1 vectors++; chk("R8 one left", timeout, 1);
    take();
    #1 vectors++; chk("R8 emptied", timeout, 0);

    // R5 R6 head tracking
    put(8'hC0, 3'b000); put(8'hC1, 3'b001); put(8'hC2, 3'b000);
    #1 vectors++; chk("R6 stored error", err_any, 1);
    vectors++; chk("R5 clean head", line_err, 0);
    take();
    #1 vectors++; chk("R5 bad head", line_err, 1);
    vectors++; chk("R5 parity bit", rd_flags, 1);
    take();
    #1 vectors++; chk("R6 error gone", err_any, 0);
    take();

    // R4 overrun
    trig = 2'd0;
    for (int i = 0; i < 16; i++) put(8'h10 + 8'(i), 3'b000);
    put(8'hEE, 3'b000);
    #1 vectors++; chk("R4 full drop", count, 16);
    drive(1, 8'h77, 3'b000, 1, 0);
    #1 vectors++; chk("R4 write with read", count, 16);
    for (int i = 0; i < 14; i++) take();
    #1 vectors++; chk("R4 tag on last", rd_flags[3], 1);
    vectors++; chk("R4 last data", rd_data, 8'h1F);
    take(); take();

    // R9 flush on mode change
    put(8'h41, 3'b010); put(8'h42, 3'b000);
    fifo_en = 0; idle_cyc();
    #1 vectors++; chk("R9 flushed", count, 0);
    vectors++; chk("R9 error cleared", err_any, 0);

    // R3 holding mode
    put(8'h5A, 3'b000);
    #1 vectors++; chk("R3 ready", data_ready, 1);
    put(8'hA5, 3'b100);
    #1 vectors++; chk("R3 overrun tag", rd_flags[3], 1);
    vectors++; chk("R3 kept byte", rd_data, 8'h5A);
    take();
    #1 vectors++; chk("R3 cleared", data_ready, 0);

    // mixed traffic
    fifo_en = 1; idle_cyc();
    for (int c = 0; c < 4000; c++) begin
      if (c % 250 == 0) trig = 2'($urandom_range(0, 3));
      if (c % 900 == 899) fifo_en = ~fifo_en;
      drive(($urandom_range(0, 99) < 40), 8'($urandom),
            {($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0)},
            ($urandom_range(0, 99) < 35), ($urandom_range(0, 99) < 25));
    end
    idle_cyc();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule